// File: doc/BRIEF.md
# Shared-memory command ring reader

This block is the consuming side of a command ring kept in a shared memory. The first four dwords of that memory form a header. Word 0 holds the lower bound of the ring and word 1 the upper bound, both as byte offsets. Word 2 holds the host's write pointer and word 3 the device's read pointer. The host appends dwords at its write pointer and then moves the pointer on. The reader fetches from its own read pointer, hands each dword downstream on a valid/ready stream, and writes its advanced pointer back to word 3. Each pointer wraps from the upper bound to the lower bound. A full ring keeps one slot unused.

The reader is gated by a configuration-done input. While that input is low it issues no new work. Each time it is raised, the reader reloads the header. A sync request sets busy, and busy stays set until the reader reads the host pointer fresh from memory and finds it equal to the read pointer. The memory side is a simple request/grant port with one access in flight. Read data returns with a response strobe, and a write completes at its grant.

Top module: `cmd_ring_reader`

## Requirements
- R1: After reset, busy_o, cmd_valid_o and mem_req_o are all 0.
- R2: While cfg_done_i is 0 and no access is in progress, no memory request is issued.
- R3: On a rise of cfg_done_i the reader reads word addresses 0, 1 and 3, in that order, and then word 2. A request is held, with a stable address and direction, until it is granted.
- R4: The ring is empty when the host pointer (word 2) equals the read pointer. While it is empty no dword is presented, and word 2 is read again repeatedly, so that later host writes are picked up.
- R5: Dwords are delivered in ring order from word address (read pointer >> 2).
- R6: A pointer advanced by 4 bytes that equals the upper bound becomes the lower bound.
- R7: The advanced read pointer is written to word 3 only after the presented dword is accepted. Only word 3 is ever written. No memory access happens while a dword is presented.
- R8: While cmd_valid_o is 1 and cmd_ready_i is 0, the valid stays high and cmd_data_o holds steady.
- R9: busy_o rises in the cycle after sync_i. It falls only after a fresh read of word 2 shows the ring empty, and it then leaves word 3 equal to word 2.
- R10: A ring of N words accepts N-1 host dwords before the host sees it full, and all of them are delivered.
- R11: When cfg_done_i falls, fetching stops after the current dword. When it rises again, a newly written header (new bounds and pointers) takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_done_i | input | 1 | Ring configured; enables fetching |
| sync_i | input | 1 | Sync request pulse |
| busy_o | output | 1 | Sync outstanding |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Dword address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request granted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Command dword valid |
| cmd_data_o | output | 32 | Command dword |
| cmd_ready_i | input | 1 | Downstream accepts |

## Verification
A stale read pointer or a wrong wrap shows at the ports within one fetch. The dword stream then goes out of order, or word 3 in memory differs from the bench's own pointer model once the ring drains. A stuck sync flag shows as busy_o still high after the ring is empty, and it is caught within a few hundred cycles of the drain. A missed re-read of the host pointer shows as host dwords that are never delivered. A lost header reload shows as fetches from the old region after configuration-done rises again.

// File: rtl/cmd_ring_pkg.sv
`timescale 1ns/1ps
package cmd_ring_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HDR_MIN  = 0;
  localparam int unsigned HDR_MAX  = 1;
  localparam int unsigned HDR_NEXT = 2;
  localparam int unsigned HDR_STOP = 3;
  localparam int unsigned STEP_B   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_HMIN, S_HMAX, S_HSTOP, S_POLL, S_FETCH, S_SEND, S_WBACK
  } rd_state_e;

  typedef enum logic [1:0] {MP_IDLE, MP_REQ, MP_RESP} mp_state_e;
endpackage

// File: rtl/cmd_ring_ptr_step.sv
`timescale 1ns/1ps
module cmd_ring_ptr_step
  import cmd_ring_pkg::*;
#(
  parameter int unsigned OFF_W = 32
) (
  input  logic [OFF_W-1:0] cur_i,
  input  logic [OFF_W-1:0] lo_i,
  input  logic [OFF_W-1:0] hi_i,
  output logic [OFF_W-1:0] nxt_o
);
  logic [OFF_W-1:0] inc;
  assign inc   = cur_i + OFF_W'(STEP_B);
  assign nxt_o = (inc == hi_i) ? lo_i : inc;
endmodule

// File: rtl/cmd_ring_mem_port.sv
`timescale 1ns/1ps
module cmd_ring_mem_port
  import cmd_ring_pkg::*;
#(
  parameter int unsigned AW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  mp_state_e     st_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= MP_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        MP_IDLE: if (start_i) begin
          st_q    <= MP_REQ;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        MP_REQ:  if (mem_gnt_i) st_q <= we_q ? MP_IDLE : MP_RESP;
        MP_RESP: if (mem_rvalid_i) st_q <= MP_IDLE;
        default: st_q <= MP_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == MP_REQ);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = (st_q == MP_REQ && mem_gnt_i && we_q) ||
                       (st_q == MP_RESP && mem_rvalid_i);
  assign rdata_o     = mem_rdata_i;
endmodule

// File: rtl/cmd_ring_reader.sv
`timescale 1ns/1ps
module cmd_ring_reader
  import cmd_ring_pkg::*;
#(
  parameter  int unsigned OFF_W = 32,
  localparam int unsigned AW    = OFF_W - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_done_i,
  input  logic          sync_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          cmd_valid_o,
  output logic [31:0]   cmd_data_o,
  input  logic          cmd_ready_i
);
  rd_state_e        state_q;
  logic             pend_q, sync_q;
  logic [OFF_W-1:0] min_q, max_q, next_q, stop_q, stop_nx, rd_off;
  logic [DW-1:0]    data_q, mp_rdata, mp_wdata;
  logic [AW-1:0]    mp_addr;
  logic             mp_we, mp_start, mp_done, op_st, empty_seen;

  cmd_ring_ptr_step #(.OFF_W(OFF_W)) u_step (
    .cur_i(stop_q), .lo_i(min_q), .hi_i(max_q), .nxt_o(stop_nx)
  );

  cmd_ring_mem_port #(.AW(AW)) u_mp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (mp_start),
    .we_i        (mp_we),
    .addr_i      (mp_addr),
    .wdata_i     (mp_wdata),
    .done_o      (mp_done),
    .rdata_o     (mp_rdata),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i)
  );

  assign rd_off   = OFF_W'(mp_rdata);
  assign mp_wdata = DW'(stop_q);
  assign op_st    = !(state_q inside {S_IDLE, S_SEND});
  assign mp_start = op_st && !pend_q;

  always_comb begin
    mp_we   = 1'b0;
    mp_addr = '0;
    case (state_q)
      S_HMIN:  mp_addr = AW'(HDR_MIN);
      S_HMAX:  mp_addr = AW'(HDR_MAX);
      S_HSTOP: mp_addr = AW'(HDR_STOP);
      S_POLL:  mp_addr = AW'(HDR_NEXT);
      S_FETCH: mp_addr = stop_q[OFF_W-1:2];
      S_WBACK: begin mp_addr = AW'(HDR_STOP); mp_we = 1'b1; end
      default: ;
    endcase
  end

  // only a fresh host-pointer read may declare the ring empty
  assign empty_seen = (state_q == S_POLL) && mp_done && (rd_off == stop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
      sync_q  <= 1'b0;
      min_q   <= '0;
      max_q   <= '0;
      next_q  <= '0;
      stop_q  <= '0;
      data_q  <= '0;
    end else begin
      if (mp_start)     pend_q <= 1'b1;
      else if (mp_done) pend_q <= 1'b0;

      if (sync_i)          sync_q <= 1'b1;
      else if (empty_seen) sync_q <= 1'b0;

      case (state_q)
        S_IDLE:  if (cfg_done_i) state_q <= S_HMIN;
        S_HMIN:  if (mp_done) begin min_q <= rd_off; state_q <= S_HMAX; end
        S_HMAX:  if (mp_done) begin max_q <= rd_off; state_q <= S_HSTOP; end
        S_HSTOP: if (mp_done) begin stop_q <= rd_off; state_q <= S_POLL; end
        S_POLL: if (mp_done) begin
          next_q <= rd_off;
          if (!cfg_done_i)          state_q <= S_IDLE;
          else if (rd_off != stop_q) state_q <= S_FETCH;
        end
        S_FETCH: if (mp_done) begin data_q <= mp_rdata; state_q <= S_SEND; end
        S_SEND: if (cmd_ready_i) begin
          stop_q  <= stop_nx;
          state_q <= S_WBACK;
        end
        S_WBACK: if (mp_done) begin
          if (!cfg_done_i)          state_q <= S_IDLE;
          else if (stop_q == next_q) state_q <= S_POLL;
          else                       state_q <= S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = sync_q;
  assign cmd_valid_o = (state_q == S_SEND);
  assign cmd_data_o  = data_q;
endmodule

// File: rtl/cmd_ring_reader_chk.sv
`timescale 1ns/1ps
module cmd_ring_reader_chk #(
  parameter int unsigned AW = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_gnt_i,
  input logic          mem_rvalid_i,
  input logic          cmd_valid_o,
  input logic [31:0]   cmd_data_o,
  input logic          cmd_ready_i
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_no_mem_in_send_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_req_o);

  p_wr_only_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_addr_o == AW'(3));

  p_hold_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o));

  p_busy_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> busy_o);

  p_busy_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_rvalid_i && !mem_we_o && mem_addr_o == AW'(2)));
endmodule

bind cmd_ring_reader cmd_ring_reader_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_data_o  (cmd_data_o),
  .cmd_ready_i (cmd_ready_i)
);

// File: tb/sim_cmd_ring_reader.sv
`timescale 1ns/1ps
module sim_cmd_ring_reader;
  localparam int unsigned AW = 30;

  logic clk = 1'b0;
  logic rst_ni, cfg_done, sync_p, busy, mreq, mwe, mgnt, mrvalid, cvalid, cready;
  logic [AW-1:0] maddr;
  logic [31:0] mwdata, mrdata, cdata;

  always #2.5 clk = ~clk;

  cmd_ring_reader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_done_i(cfg_done), .sync_i(sync_p),
    .busy_o(busy), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_gnt_i(mgnt), .mem_rvalid_i(mrvalid),
    .mem_rdata_i(mrdata), .cmd_valid_o(cvalid), .cmd_data_o(cdata),
    .cmd_ready_i(cready)
  );

  int unsigned mem [0:1023];
  int unsigned rlog [0:7];
  int nlog = 0, nacc = 0, npoll = 0;
  int total = 0, bad = 0;
  bit gnt_en = 1'b0;
  int rdy_mode = 1;
  int unsigned exp_q[$], rcv_q[$];
  int unsigned hmin, hmax, hnext;

  assign mgnt = mreq && gnt_en;

  // memory model: grant gated at random, read data one cycle after grant
  always @(posedge clk) begin
    mrvalid <= 1'b0;
    if (mreq && gnt_en) begin
      nacc = nacc + 1;
      if (mwe) mem[maddr[9:0]] <= mwdata;
      else begin
        mrdata  <= mem[maddr[9:0]];
        mrvalid <= 1'b1;
        if (nlog < 8) begin rlog[nlog] = 32'(maddr); nlog = nlog + 1; end
        if (maddr == AW'(2)) npoll = npoll + 1;
      end
    end
  end

  // stimulus for grant and ready; capture of accepted dwords
  initial begin
    cready = 1'b0;
    forever begin
      @(negedge clk);
      gnt_en = ($urandom % 4) != 0;
      case (rdy_mode)
        0: cready = 1'b0;
        1: cready = 1'b1;
        default: cready = ($urandom % 3) != 0;
      endcase
      if (cvalid && cready) rcv_q.push_back(cdata);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int unsigned step(input int unsigned p);
    int unsigned n = p + 4;
    return (n == hmax) ? hmin : n;
  endfunction

  task automatic try_push(input int unsigned d, output bit ok);
    int unsigned n = step(hnext);
    if (n == mem[3]) ok = 1'b0;
    else begin
      mem[hnext >> 2] = d;
      mem[2] = n;
      hnext = n;
      exp_q.push_back(d);
      ok = 1'b1;
    end
  endtask

  task automatic push(input int unsigned d);
    bit ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      try_push(d, ok);
    end
  endtask

  task automatic drain(input string req);
    int t = 0;
    int mism = 0;
    int unsigned a = 0, e = 0;
    while (rcv_q.size() < exp_q.size() && t < 20000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    if (rcv_q.size() != exp_q.size()) mism = 1;
    else
      for (int i = 0; i < exp_q.size(); i++)
        if (rcv_q[i] != exp_q[i] && mism == 0) begin mism = 1; a = rcv_q[i]; e = exp_q[i]; end
    chk(rcv_q.size() == exp_q.size(), req, rcv_q.size(), exp_q.size());
    chk(mism == 0 || rcv_q.size() != exp_q.size(), req, a, e);
    exp_q.delete();
    rcv_q.delete();
  endtask

  task automatic set_hdr(input int unsigned lo, input int unsigned words);
    hmin = lo; hmax = lo + 4 * words; hnext = lo;
    mem[0] = hmin; mem[1] = hmax; mem[2] = lo; mem[3] = lo;
  endtask

  task automatic wait_idle_busy(input int lim);
    int t = 0;
    while (busy && t < lim) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, cnt;
    bit ok;
    void'($urandom(32'd4711));
    rst_ni = 1'b0; cfg_done = 1'b0; sync_p = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    set_hdr(16, 12);
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !cvalid && !mreq, "R1", {busy, cvalid, mreq}, 0);
    repeat (20) @(negedge clk);
    chk(nacc == 0, "R2", nacc, 0);

    cfg_done = 1'b1;
    repeat (60) @(negedge clk);
    chk(nlog >= 4, "R3", nlog, 4);
    chk(rlog[0] == 0 && rlog[1] == 1 && rlog[2] == 3 && rlog[3] == 2, "R3",
        {rlog[0][7:0], rlog[1][7:0], rlog[2][7:0], rlog[3][7:0]}, 32'h00010302);

    base = npoll;
    repeat (40) @(negedge clk);
    chk(rcv_q.size() == 0, "R4", rcv_q.size(), 0);
    chk(npoll > base, "R4", npoll, base + 1);

    rdy_mode = 2;
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
    drain("R5");

    for (int i = 0; i < 300; i++) push($urandom);
    drain("R6");
    repeat (20) @(negedge clk);
    chk(mem[3] == hnext, "R7", mem[3], hnext);

    // full ring: 12 words hold 11
    rdy_mode = 0;
    repeat (30) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      try_push(32'hF000_0000 + i, ok);
      if (ok) cnt++;
    end
    chk(cnt == 11, "R10", cnt, 11);
    @(negedge clk) sync_p = 1'b1;
    @(negedge clk) sync_p = 1'b0;
    chk(busy == 1'b1, "R9", busy, 1);
    repeat (50) @(negedge clk);
    chk(busy == 1'b1, "R9", busy, 1);
    rdy_mode = 2;
    wait_idle_busy(3000);
    chk(!busy, "R9", busy, 0);
    chk(mem[3] == mem[2], "R9", mem[3], mem[2]);
    drain("R10");
    chk(mem[3] == hnext, "R6", mem[3], hnext);

    // sync on an empty ring
    @(negedge clk) sync_p = 1'b1;
    @(negedge clk) sync_p = 1'b0;
    chk(busy == 1'b1, "R9", busy, 1);
    wait_idle_busy(200);
    chk(!busy, "R9", busy, 0);

    // gating and header reload
    cfg_done = 1'b0;
    repeat (60) @(negedge clk);
    set_hdr(256, 8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      try_push(32'h5500_0000 + i, ok);
    end
    base = nacc;
    repeat (100) @(negedge clk);
    chk(rcv_q.size() == 0, "R11", rcv_q.size(), 0);
    chk(nacc == base, "R2", nacc, base);
    cfg_done = 1'b1;
    drain("R11");
    repeat (20) @(negedge clk);
    chk(mem[3] == hnext, "R11", mem[3], hnext);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule